// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block sits between up to six asynchronous interrupt pins and one interrupt controller. Each pin is first synchronised to the system clock. It is then checked against a trigger mode that software selects for that pin. The result is one request line per pin, and each line feeds one source of the downstream controller.

There are two kinds of trigger mode. In an edge mode, a detected transition sets a sticky pending bit. That bit holds until software clears it. In a level mode, the request simply follows the pin while the selected polarity is present. An enable bit for each pin decides whether its request reaches the output.

Software reaches four 32-bit registers over a simple register bus:

| Offset | Register | Behaviour |
|---|---|---|
| 0x00 | Mode | 4-bit mode field per pin |
| 0x04 | Level view | Read-only view of the synchronised pin levels |
| 0x08 | Pending | Writing 0 to a bit clears that pin's pending bit |
| 0x0C | Enable | One enable bit per pin |

A typical bring-up for a pin takes three writes: set its mode to active-low level, clear its pending bit, then set its enable bit.

Top module: `extint_cond`

## Requirements
- R1: After a synchronous reset, all of the following are zero: the mode, pending and enable registers, every request output, and read data.
- R2: Register 0x00 holds the pin modes, with pin i's mode in bits [4i+3:4i]. Bits above the six fields read as zero. A write replaces the whole register.
- R3: Mode 1 (rising edge): a 0-to-1 transition of the synchronised pin sets pending bit i. The bit stays set after the pin returns low.
- R4: Mode 2 (falling edge): only a 1-to-0 transition sets pending bit i. A rising transition does not.
- R5: Mode 3 (both edges): either transition sets pending bit i.
- R6: Mode 5 (high level): the request follows the synchronised pin while it is high, and the pending bit is never set.
- R7: Mode 6 (low level): the request follows the synchronised pin while it is low, and the pending bit is never set.
- R8: Mode codes 0, 4, 7 and 8 to 15 never set pending and never raise the request.
- R9: Register 0x08 reads back the pending bits in bits [5:0]. Writing it clears pending bit i where write bit i is 0 and keeps every bit written as 1.
- R10: Register 0x0C bit i gates request output i. Pending bits are still captured while the pin is disabled, and they appear on the output once it is enabled.
- R11: Register 0x04 reads the synchronised pin levels in bits [5:0], and writes to it have no effect.
- R12: A pin change reaches the output on the third rising clock edge after it is applied in a level mode, and on the fourth edge in an edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 6 | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid one cycle later |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 6 | Request lines to the interrupt controller, one per pin |

## Verification
Each pin mode is driven with a rise followed by a fall. This separates rising, falling and dual-edge capture, and it shows whether a level mode follows the pin rather than latching it. The same pulse is applied under every unused code to show that those codes stay silent. A pin that is pulsed while its enable bit is off tells output gating apart from loss of the event. Two pending bits cleared by a single write with mixed ones and zeros tell a per-bit clear apart from a whole-register clear. The edge-to-output latency is sampled cycle by cycle for both a level mode and an edge mode.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [3:0] {
    TM_OFF  = 4'd0,
    TM_RISE = 4'd1,
    TM_FALL = 4'd2,
    TM_BOTH = 4'd3,
    TM_HIGH = 4'd5,
    TM_LOW  = 4'd6
  } trig_mode_e;

  localparam int MODE_W   = 4;
  localparam int OFS_MODE = 'h0;
  localparam int OFS_LVL  = 'h4;
  localparam int OFS_PEND = 'h8;
  localparam int OFS_EN   = 'hC;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extint_cell.sv
module extint_cell
  import extint_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              lvl,
  input  logic              clr,
  input  logic              en,
  output logic              pend,
  output logic              irq
);
  logic prev_q;
  logic pend_q;
  logic irq_q;
  logic rise, fall, event_hit, level_hit;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    event_hit = 1'b0;
    level_hit = 1'b0;
    case (mode)
      TM_RISE: event_hit = rise;
      TM_FALL: event_hit = fall;
      TM_BOTH: event_hit = rise | fall;
      TM_HIGH: level_hit = lvl;
      TM_LOW:  level_hit = ~lvl;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      // a new event wins over a simultaneous clear, so no event is lost
      if (event_hit)  pend_q <= 1'b1;
      else if (clr)   pend_q <= 1'b0;
      irq_q <= en & (level_hit | pend_q);
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;
endmodule

// File: rtl/extint_cond.sv
module extint_cond
  import extint_pkg::*;
#(
  parameter int N_PINS      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] ext_pin,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_PINS-1:0] irq_o
);
  localparam int CFG_W = N_PINS * MODE_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [N_PINS-1:0] en_q;
  logic [N_PINS-1:0] pin_s;
  logic [N_PINS-1:0] pend_vec;
  logic [DATA_W-1:0] rdata_q;
  logic              sel_mode, sel_lvl, sel_pend, sel_en;
  logic              unused_wdata;

  assign sel_mode = (reg_addr == ADDR_W'(OFS_MODE));
  assign sel_lvl  = (reg_addr == ADDR_W'(OFS_LVL));
  assign sel_pend = (reg_addr == ADDR_W'(OFS_PEND));
  assign sel_en   = (reg_addr == ADDR_W'(OFS_EN));
  assign unused_wdata = ^reg_wdata[DATA_W-1:CFG_W];

  extint_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_pin),
    .q   (pin_s)
  );

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      extint_cell u_cell (
        .clk  (clk),
        .rst  (rst),
        .mode (cfg_q[i*MODE_W +: MODE_W]),
        .lvl  (pin_s[i]),
        .clr  (reg_wr & sel_pend & ~reg_wdata[i]),
        .en   (en_q[i]),
        .pend (pend_vec[i]),
        .irq  (irq_o[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else if (reg_wr) begin
      if (sel_mode) cfg_q <= reg_wdata[CFG_W-1:0];
      if (sel_en)   en_q  <= reg_wdata[N_PINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= '0;
      if (sel_mode) rdata_q[CFG_W-1:0]  <= cfg_q;
      if (sel_lvl)  rdata_q[N_PINS-1:0] <= pin_s;
      if (sel_pend) rdata_q[N_PINS-1:0] <= pend_vec;
      if (sel_en)   rdata_q[N_PINS-1:0] <= en_q;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/extint_chk.sv
module extint_chk
  import extint_pkg::*;
#(
  parameter int N_PINS = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wdata,
  input logic [N_PINS*MODE_W-1:0]   cfg,
  input logic [N_PINS-1:0]          en,
  input logic [N_PINS-1:0]          pend,
  input logic [N_PINS-1:0]          irq
);
  // R1: first cycle out of reset shows a quiet block
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0 && pend == '0 && en == '0 && cfg == '0));

  // R2: a mode write is stored as written
  p_cfg_store_r2: assert property (@(posedge clk) disable iff (rst)
    $past(wr && addr == ADDR_W'(OFS_MODE)) |-> cfg == $past(wdata[N_PINS*MODE_W-1:0]));

  // R9: a pending bit falls only after a write to the pending register
  p_pend_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend) & ~pend)) |-> $past(wr && addr == ADDR_W'(OFS_PEND)));

  // R10: no request leaves while its enable bit was off
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    (irq & ~$past(en)) == '0);
endmodule

bind extint_cond extint_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr    (reg_wr),
  .addr  (reg_addr),
  .wdata (reg_wdata),
  .cfg   (cfg_q),
  .en    (en_q),
  .pend  (pend_vec),
  .irq   (irq_o)
);

// File: tb/sim_extint_cond.sv
`timescale 1ns/1ps
module sim_extint_cond;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  pins = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  extint_cond u0 (
    .clk(clk), .rst(rst), .ext_pin(pins), .reg_wr(wr), .reg_rd(rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {26'd0, irq}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    bus_read(4'h0, v); chk("R1 mode", v, 32'h0);
    bus_read(4'h8, v); chk("R1 pend", v, 32'h0);
    bus_read(4'hC, v); chk("R1 en", v, 32'h0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, v); chk("R2 upper bits zero", v, 32'h00FF_FFFF);
    bus_write(4'h0, 32'h00A5_C3E1);
    bus_read(4'h0, v); chk("R2 pattern", v, 32'h00A5_C3E1);
    bus_write(4'h0, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    pins = 6'b101101; wait_n(4);
    bus_read(4'h4, v); chk("R11 levels", v, 32'h2D);
    bus_write(4'h4, 32'h3F);
    bus_read(4'h4, v); chk("R11 write ignored", v, 32'h2D);
    pins = '0; wait_n(4);
    bus_read(4'h4, v); chk("R11 levels low", v, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    bus_write(4'h0, 32'h1);
    bus_write(4'h8, 32'h0);
    bus_write(4'hC, 32'h01);
    @(negedge clk); pins[0] = 1'b1;
    wait_n(3); chk("R12 edge not yet", {31'd0, irq[0]}, 32'h0);
    wait_n(1); chk("R12 edge latency R3", {31'd0, irq[0]}, 32'h1);
    pins[0] = 1'b0; wait_n(5);
    chk("R3 sticky irq", {31'd0, irq[0]}, 32'h1);
    bus_read(4'h8, v); chk("R3 pending", v, 32'h01);
    bus_write(4'h8, 32'h3E);
    bus_read(4'h8, v); chk("R9 cleared", v, 32'h0);
    wait_n(2); chk("R9 irq dropped", {26'd0, irq}, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    bus_write(4'h0, 32'h20);
    bus_write(4'hC, 32'h02);
    pins[1] = 1'b1; wait_n(5);
    bus_read(4'h8, v); chk("R4 rise ignored", v, 32'h0);
    pins[1] = 1'b0; wait_n(5);
    bus_read(4'h8, v); chk("R4 fall pending", v, 32'h02);
    chk("R4 irq", {26'd0, irq}, 32'h02);
    bus_write(4'h8, 32'h3D); wait_n(2);
  endtask

  task automatic t_both();
    logic [31:0] v;
    bus_write(4'h0, 32'h300);
    bus_write(4'hC, 32'h04);
    pins[2] = 1'b1; wait_n(5);
    bus_read(4'h8, v); chk("R5 rise", v, 32'h04);
    bus_write(4'h8, 32'h0);
    bus_read(4'h8, v); chk("R5 cleared", v, 32'h0);
    pins[2] = 1'b0; wait_n(5);
    bus_read(4'h8, v); chk("R5 fall", v, 32'h04);
    bus_write(4'h8, 32'h0); wait_n(2);
  endtask

  task automatic t_high();
    logic [31:0] v;
    bus_write(4'h0, 32'h5000);
    bus_write(4'hC, 32'h08);
    @(negedge clk); pins[3] = 1'b1;
    wait_n(2); chk("R12 level not yet", {26'd0, irq}, 32'h0);
    wait_n(1); chk("R12 level latency R6", {26'd0, irq}, 32'h08);
    bus_read(4'h8, v); chk("R6 no pending", v, 32'h0);
    pins[3] = 1'b0; wait_n(4);
    chk("R6 follows low", {26'd0, irq}, 32'h0);
  endtask

  task automatic t_low();
    logic [31:0] v;
    pins[4] = 1'b1; wait_n(4);
    bus_write(4'h0, 32'h60000);
    bus_write(4'h8, 32'h2F);
    bus_write(4'hC, 32'h10);
    wait_n(3); chk("R7 idle high", {26'd0, irq}, 32'h0);
    pins[4] = 1'b0; wait_n(4);
    chk("R7 asserted low", {26'd0, irq}, 32'h10);
    bus_read(4'h8, v); chk("R7 no pending", v, 32'h0);
    pins[4] = 1'b1; wait_n(4);
    chk("R7 released", {26'd0, irq}, 32'h0);
    pins[4] = 1'b0; bus_write(4'hC, 32'h0); wait_n(2);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    logic [3:0] codes [5] = '{4'd0, 4'd4, 4'd7, 4'd8, 4'd15};
    bus_write(4'hC, 32'h20);
    for (int c = 0; c < 5; c++) begin
      bus_write(4'h0, {8'd0, codes[c], 20'd0});
      pins[5] = 1'b1; wait_n(4);
      chk($sformatf("R8 code %0d high", codes[c]), {26'd0, irq}, 32'h0);
      pins[5] = 1'b0; wait_n(4);
      chk($sformatf("R8 code %0d low", codes[c]), {26'd0, irq}, 32'h0);
      bus_read(4'h8, v); chk($sformatf("R8 code %0d pend", codes[c]), v, 32'h0);
    end
    bus_write(4'hC, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    bus_write(4'h0, 32'h21);
    bus_write(4'hC, 32'h0);
    pins[1] = 1'b1; pins[0] = 1'b1; wait_n(5);
    chk("R10 gated", {26'd0, irq}, 32'h0);
    pins[1] = 1'b0; wait_n(5);
    bus_read(4'h8, v); chk("R10 captured while off", v, 32'h03);
    bus_write(4'hC, 32'h01); wait_n(2);
    chk("R10 shown on enable", {26'd0, irq}, 32'h01);
    bus_write(4'h8, 32'h3E);
    bus_read(4'h8, v); chk("R9 per-bit clear", v, 32'h02);
    bus_write(4'h8, 32'h0);
    bus_read(4'h8, v); chk("R9 clear all", v, 32'h0);
    pins[0] = 1'b0; bus_write(4'hC, 32'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wait_n(100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_cfg();
    t_capture();
    t_rise();
    t_fall();
    t_both();
    t_high();
    t_low();
    t_unused();
    t_enable();
    finish_run();
  end
endmodule